// File: doc/BRIEF.md
# Word-to-Byte Transmit Buffer with Selectable Byte Order

This block sits between a 32-bit writer (a processor or a DMA engine) and a byte-wide serial transmitter. Each accepted word is stored in an eight-entry queue. Each word is then split into four bytes and handed to the transmitter in a byte order chosen by a configuration input. One order sends the low byte first. The other sends the high byte first. A word leaves the queue only after its fourth byte has been taken.

The write port has no back-pressure. The writer reads two space flags to decide how much it may send. One flag means at least one word slot is free. The other means at least four word slots are free. A write that arrives while the queue is full is dropped and sets a sticky overflow flag.

Each space flag can raise an interrupt through its own enable, and a global enable gates both. In DMA mode the interrupt is held low, and a request line asks for data while at least one slot is free.

The byte output is valid/ready. `tx_valid` stays high while any stored byte remains. `tx_data` and the byte position stay fixed while `tx_ready` is low. A byte counts as taken only in a cycle where both `tx_valid` and `tx_ready` are high.

Top module: `endian_tx_fifo`

## Requirements
- R1: After reset the queue is empty: `tx_valid`=0, `st_ready`=1, `st_half`=1, `st_overflow`=0, and `irq` and `dma_req` are 0 when all control enables are 0.
- R2: With `cfg_big_endian`=0 a word is emitted low byte first: writing 0x11223344 yields 0x44, 0x33, 0x22, 0x11.
- R3: With `cfg_big_endian`=1 a word is emitted high byte first: writing 0xA1B2C3D4 yields 0xA1, 0xB2, 0xC3, 0xD4.
- R4: While `tx_valid`=1 and `tx_ready`=0, `tx_data` holds its value. A word's slot is freed only when its fourth byte is taken.
- R5: `st_ready` is 1 exactly when at least one of the 8 word slots is free.
- R6: `st_half` is 1 exactly when at least four word slots are free, that is when 4 or fewer words are stored.
- R7: With `cfg_dma_mode`=0, `irq` = `cfg_irq_en` AND ((`st_ready` AND `cfg_ready_ie`) OR (`st_half` AND `cfg_half_ie`)).
- R8: With `cfg_dma_mode`=1, `irq` is 0 whatever the enables are. `dma_req` is 1 while a slot is free and 0 in any cycle the queue is full. With `cfg_dma_mode`=0, `dma_req` is 0.
- R9: A write while the queue is full is dropped and sets `st_overflow`. The flag stays set until a cycle with `ovf_clr`=1 clears it, and a new overflow in that same cycle takes priority over the clear.
- R10: Words are emitted in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write strobe for one word |
| wr_data | input | 32 | Word to store |
| tx_valid | output | 1 | A byte is offered to the transmitter |
| tx_ready | input | 1 | The transmitter takes the offered byte |
| tx_data | output | 8 | Offered byte |
| cfg_big_endian | input | 1 | 1: high byte first, 0: low byte first |
| cfg_ready_ie | input | 1 | Interrupt enable for the one-slot-free flag |
| cfg_half_ie | input | 1 | Interrupt enable for the four-slots-free flag |
| cfg_irq_en | input | 1 | Global interrupt enable |
| cfg_dma_mode | input | 1 | Enables the DMA request and masks the interrupt |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| st_ready | output | 1 | At least one word slot free |
| st_half | output | 1 | At least four word slots free |
| st_overflow | output | 1 | Sticky flag for a dropped write |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The hardest state to reach is a full queue whose head word is partly sent. In that state a fourth byte decides whether a slot frees. The bench fills all eight slots, takes three bytes, and checks that `st_ready` is still low. It then takes the fourth byte and checks that `st_ready` rises. The overflow case is reached by writing into the full queue. Draining afterwards shows that the dropped word never appears and that the eight stored words come out in order.

// File: rtl/tx_pack_pkg.sv
package tx_pack_pkg;
  typedef enum logic {
    ORDER_LOW_FIRST  = 1'b0,
    ORDER_HIGH_FIRST = 1'b1
  } byte_order_e;
endpackage

// File: rtl/word_fifo.sv
module word_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r4_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
endmodule

// File: rtl/byte_unpacker.sv
module byte_unpacker
  import tx_pack_pkg::*;
#(
  parameter int W      = 32,
  parameter int BYTE_W = 8,
  localparam int LANES = W / BYTE_W,
  localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      word,
  input  logic              word_valid,
  input  byte_order_e       order,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              word_done
);
  logic [BYTE_W-1:0] lane [LANES];
  logic [IW-1:0]     idx, sel;
  logic              take;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word[g*BYTE_W +: BYTE_W];
  end

  assign out_valid = word_valid;
  assign take      = out_valid && out_ready;
  assign word_done = take && (idx == IW'(LANES - 1));
  assign sel       = (order == ORDER_HIGH_FIRST) ? IW'(LANES - 1) - idx : idx;
  assign out_data  = lane[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         idx <= '0;
    else if (word_done) idx <= '0;
    else if (take)      idx <= idx + 1'b1;
  end

  a_r4_hold_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(idx));
endmodule

// File: rtl/space_flags.sv
module space_flags #(
  parameter int DEPTH      = 8,
  parameter int HALF_WORDS = 4,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          ready_ie,
  input  logic          half_ie,
  input  logic          irq_en,
  input  logic          dma_mode,
  output logic          ready_flag,
  output logic          half_flag,
  output logic          irq,
  output logic          dma_req
);
  logic [CW-1:0] free_slots;

  assign free_slots = CW'(DEPTH) - count;
  assign ready_flag = free_slots >= CW'(1);
  assign half_flag  = free_slots >= CW'(HALF_WORDS);
  assign irq        = irq_en && !dma_mode &&
                      ((ready_flag && ready_ie) || (half_flag && half_ie));
  assign dma_req    = dma_mode && ready_flag;

  a_r8_dma_masks_irq: assert property (@(posedge clk) disable iff (!rst_n)
    dma_mode |-> !irq);
  a_r8_no_req_full: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) |-> !dma_req);
  a_r6_half_implies_ready: assert property (@(posedge clk) disable iff (!rst_n)
    half_flag |-> ready_flag);
endmodule

// File: rtl/endian_tx_fifo.sv
module endian_tx_fifo
  import tx_pack_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int HALF_WORDS = 4,
  parameter int W          = 32,
  parameter int BYTE_W     = 8,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [W-1:0]      wr_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              cfg_big_endian,
  input  logic              cfg_ready_ie,
  input  logic              cfg_half_ie,
  input  logic              cfg_irq_en,
  input  logic              cfg_dma_mode,
  input  logic              ovf_clr,
  output logic              st_ready,
  output logic              st_half,
  output logic              st_overflow,
  output logic              irq,
  output logic              dma_req
);
  logic [CW-1:0] count;
  logic [W-1:0]  head;
  logic          full, push, pop, ovf_hit;
  byte_order_e   order;

  assign full    = (count == CW'(DEPTH));
  assign push    = wr_valid && !full;
  assign ovf_hit = wr_valid && full;
  assign order   = cfg_big_endian ? ORDER_HIGH_FIRST : ORDER_LOW_FIRST;

  word_fifo #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(wr_data),
    .pop(pop), .rdata(head), .count(count)
  );

  byte_unpacker #(.W(W), .BYTE_W(BYTE_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .word(head), .word_valid(count != '0),
    .order(order), .out_ready(tx_ready), .out_valid(tx_valid),
    .out_data(tx_data), .word_done(pop)
  );

  space_flags #(.DEPTH(DEPTH), .HALF_WORDS(HALF_WORDS)) u_flags (
    .clk(clk), .rst_n(rst_n), .count(count),
    .ready_ie(cfg_ready_ie), .half_ie(cfg_half_ie), .irq_en(cfg_irq_en),
    .dma_mode(cfg_dma_mode), .ready_flag(st_ready), .half_flag(st_half),
    .irq(irq), .dma_req(dma_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st_overflow <= 1'b0;
    else if (ovf_hit) st_overflow <= 1'b1;
    else if (ovf_clr) st_overflow <= 1'b0;
  end

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_overflow && !ovf_clr) |=> st_overflow);
  a_r9_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && full && !pop) |=> $stable(count));
  a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && full) |=> st_overflow);
  a_r4_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !wr_valid && $stable(cfg_big_endian)) |=> $stable(tx_data));
endmodule

// File: tb/endian_tx_fifo_tb.sv
module endian_tx_fifo_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic tx_valid, tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic cfg_big_endian = 1'b0, cfg_ready_ie = 1'b0, cfg_half_ie = 1'b0;
  logic cfg_irq_en = 1'b0, cfg_dma_mode = 1'b0, ovf_clr = 1'b0;
  logic st_ready, st_half, st_overflow, irq, dma_req;

  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  endian_tx_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .cfg_big_endian(cfg_big_endian), .cfg_ready_ie(cfg_ready_ie),
    .cfg_half_ie(cfg_half_ie), .cfg_irq_en(cfg_irq_en),
    .cfg_dma_mode(cfg_dma_mode), .ovf_clr(ovf_clr),
    .st_ready(st_ready), .st_half(st_half), .st_overflow(st_overflow),
    .irq(irq), .dma_req(dma_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] w);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = w;
    @(negedge clk);
    wr_valid = 1'b0;
    #1;
  endtask

  task automatic take_byte(output logic v, output logic [7:0] b);
    @(negedge clk);
    tx_ready = 1'b1;
    #1;
    v = tx_valid;
    b = tx_data;
    @(posedge clk);
    #1;
    tx_ready = 1'b0;
  endtask

  task automatic drain_word(input string req, input logic [31:0] w);
    for (int i = 0; i < 4; i++) begin
      logic v;
      logic [7:0] b, e;
      take_byte(v, b);
      e = cfg_big_endian ? w[(3-i)*8 +: 8] : w[i*8 +: 8];
      check(req, {31'd0, v}, 32'd1);
      check(req, {24'd0, b}, {24'd0, e});
    end
  endtask

  task automatic t_reset;
    #1;
    check("R1 tx_valid", {31'd0, tx_valid}, 0);
    check("R1 st_ready", {31'd0, st_ready}, 1);
    check("R1 st_half", {31'd0, st_half}, 1);
    check("R1 st_overflow", {31'd0, st_overflow}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 dma_req", {31'd0, dma_req}, 0);
  endtask

  task automatic t_little;
    cfg_big_endian = 1'b0;
    write_word(32'h11223344);
    drain_word("R2 low-first", 32'h11223344);
    #1 check("R2 empty after word", {31'd0, tx_valid}, 0);
  endtask

  task automatic t_big;
    cfg_big_endian = 1'b1;
    write_word(32'hA1B2C3D4);
    drain_word("R3 high-first", 32'hA1B2C3D4);
    cfg_big_endian = 1'b0;
  endtask

  task automatic t_flags_irq;
    cfg_irq_en = 1'b1;
    cfg_ready_ie = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      write_word(32'h100 + k);
      check("R5 st_ready", {31'd0, st_ready}, (k < 8) ? 1 : 0);
      check("R6 st_half", {31'd0, st_half}, (k <= 4) ? 1 : 0);
      check("R7 irq ready_ie", {31'd0, irq}, (k < 8) ? 1 : 0);
    end
    cfg_ready_ie = 1'b0;
    cfg_half_ie  = 1'b1;
    #1 check("R7 irq half_ie full", {31'd0, irq}, 0);
    cfg_irq_en = 1'b0;
    cfg_ready_ie = 1'b1;
    #1 check("R7 global gate", {31'd0, irq}, 0);
    for (int k = 1; k <= 8; k++) drain_word("R10 order", 32'h100 + k);
    cfg_irq_en = 1'b1;
    cfg_ready_ie = 1'b0;
    #1 check("R7 irq half_ie empty", {31'd0, irq}, 1);
    cfg_irq_en = 1'b0;
    cfg_half_ie = 1'b0;
  endtask

  task automatic t_backpressure;
    logic v;
    logic [7:0] b;
    for (int k = 0; k < 8; k++) write_word(32'hC0DE0000 + k);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      check("R4 hold data", {24'd0, tx_data}, 32'h00);
    end
    for (int i = 0; i < 3; i++) take_byte(v, b);
    #1 check("R4 slot not freed", {31'd0, st_ready}, 0);
    take_byte(v, b);
    check("R4 fourth byte", {24'd0, b}, 32'hC0);
    #1 check("R4 slot freed", {31'd0, st_ready}, 1);
    for (int k = 1; k < 8; k++) drain_word("R10 order", 32'hC0DE0000 + k);
  endtask

  task automatic t_overflow;
    for (int k = 0; k < 8; k++) write_word(32'h5A000000 + k);
    check("R9 no flag yet", {31'd0, st_overflow}, 0);
    write_word(32'hDEADBEEF);
    check("R9 flag set", {31'd0, st_overflow}, 1);
    repeat (3) @(negedge clk);
    #1 check("R9 sticky", {31'd0, st_overflow}, 1);
    @(negedge clk);
    ovf_clr = 1'b1;
    wr_valid = 1'b1;
    wr_data = 32'hDEADBEEF;
    @(negedge clk);
    ovf_clr = 1'b0;
    wr_valid = 1'b0;
    #1 check("R9 set beats clear", {31'd0, st_overflow}, 1);
    @(negedge clk);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    #1 check("R9 cleared", {31'd0, st_overflow}, 0);
    for (int k = 0; k < 8; k++) drain_word("R10 R9 drop", 32'h5A000000 + k);
    #1 check("R9 dropped word absent", {31'd0, tx_valid}, 0);
  endtask

  task automatic t_dma;
    cfg_dma_mode = 1'b1;
    cfg_irq_en = 1'b1;
    cfg_ready_ie = 1'b1;
    cfg_half_ie = 1'b1;
    #1 check("R8 irq masked", {31'd0, irq}, 0);
    check("R8 req empty", {31'd0, dma_req}, 1);
    for (int k = 0; k < 7; k++) write_word(32'h77000000 + k);
    check("R8 req one free", {31'd0, dma_req}, 1);
    write_word(32'h77000007);
    check("R8 req full", {31'd0, dma_req}, 0);
    check("R8 irq still masked", {31'd0, irq}, 0);
    cfg_dma_mode = 1'b0;
    #1 check("R8 no req off mode", {31'd0, dma_req}, 0);
    for (int k = 0; k < 8; k++) drain_word("R10 order", 32'h77000000 + k);
    cfg_irq_en = 1'b0;
    cfg_ready_ie = 1'b0;
    cfg_half_ie = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_little;
    t_big;
    t_flags_irq;
    t_backpressure;
    t_overflow;
    t_dma;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule